// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with Victim Parking

This block is a direct-mapped data cache that sits between a processor's load/store port and a word-wide memory bus. It holds 256 lines of four 32-bit words. Each line carries a valid flag, a dirty flag and a tag. Stores that hit change only the cached copy and mark the line dirty. A store that misses first brings the whole line in, then merges the stored word. Memory is written only when a dirty line is displaced.

When a miss displaces a dirty line, the old line is copied into a one-line victim buffer at the moment the miss is accepted. The bus then reads the requested line first, and the processor's request completes. The parked victim is written out after that, in the background. Hits continue to be served while the write-out is in progress. A later miss waits until the buffer has drained.

The processor holds `cpu_req` and its address and data steady until `cpu_done` is high. The access takes effect on the rising edge that ends that cycle. The bus has fixed timing. An address cycle is followed by four beats. Each beat comes after a fixed wait that the memory needs for each access.

Top module: `wb_cache`

## Requirements
- R1: Address bits [3:2] select the word in a line and bits [11:4] select one of 256 lines. Bits [31:12] form the tag. Two addresses that differ only in bits [3:2] share a line, and a change in any tag bit (for example bit 12) is a miss.
- R2: After reset every line is invalid and the bus is quiet, so the first access to any address is a miss.
- R3: A load that hits asserts `cpu_done` in the same cycle the request is presented, returns the cached word on `cpu_rdata` and starts no bus transaction.
- R4: A store that hit updates the cached word without any bus transaction, and a later load of that word returns the stored value.
- R5: A miss that replaces an invalid or clean line causes exactly one bus read of the requested line and no write.
- R6: A miss that replaces a dirty line reads the new line before any write starts. The displaced line is then written to its own block address, with the values it held in the cache.
- R7: A store miss fetches the line, merges the stored word and leaves the line dirty. The other words keep their fetched values, and the stored word reaches memory when the line is later displaced.
- R8: A bus transaction is one cycle with `mem_cmd` high, followed by four one-cycle beats with `mem_beat` high. `mem_word` counts 0, 1, 2, 3 on those beats. Each beat comes 16 cycles after the previous event (the command or the previous beat), so a line takes 65 bus cycles from the command to the last beat.
- R9: A miss completes only after the whole line is filled. With an idle bus, `cpu_done` rises 66 cycles after the request is first presented.
- R10: Loads and stores that hit are served with no stall while a parked victim is being written.
- R11: A miss that arrives while the victim buffer still holds an unwritten line stalls. Its bus read command comes two cycles after the last write beat.
- R12: `mem_addr` and `mem_we` stay constant from a transaction's command cycle through its last beat. `mem_addr` carries the line address with bits [3:0] zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address of the word accessed |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | Request completes at the end of this cycle |
| cpu_rdata | output | 32 | Load data, valid while `cpu_done` is high |
| mem_cmd | output | 1 | Bus address cycle of a transaction |
| mem_we | output | 1 | Transaction direction, 1 = write to memory |
| mem_addr | output | 32 | Line address of the transaction |
| mem_beat | output | 1 | Data transfer beat |
| mem_word | output | 2 | Word of the line moved on this beat |
| mem_wdata | output | 32 | Write data during write beats |
| mem_rdata | input | 32 | Read data, sampled during read beats |

## Verification
The cache is driven by directed sequences and by random loads and stores. The random traffic is confined to a few lines and four tags, so hits, conflicts, clean evictions and dirty evictions all occur often. The directed cases each separate one outcome. A word-select change versus a tag-bit change separates a hit from a miss. A clean victim versus a dirty victim separates a read-only miss from a read followed by a write. A hit issued during a write-out separates background draining from a stall. A second miss issued right behind a dirty eviction checks that the read waits for the write. Every load is compared with a flat model of memory contents, and every writeback is seen by later loads. A mistake in merging words, choosing the victim or ordering the bus therefore shows up as a wrong value.

// File: rtl/wb_cache_pkg.sv
package wb_cache_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE,
    BUS_ADDR,
    BUS_WAIT,
    BUS_BEAT
  } bus_phase_e;

  typedef enum logic {
    CTL_IDLE,
    CTL_FILL
  } ctl_state_e;

endpackage

// File: rtl/wb_cache_bus_seq.sv
module wb_cache_bus_seq
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LINE_WORDS  = 4,
  parameter int ACCESS_WAIT = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          start_we_i,
  input  logic [ADDR_W-1:0]             start_addr_i,
  output logic                          busy_o,
  output logic                          last_o,
  output logic                          cmd_o,
  output logic                          we_o,
  output logic [ADDR_W-1:0]             addr_o,
  output logic                          beat_o,
  output logic [$clog2(LINE_WORDS)-1:0] word_o
);
  localparam int WSEL_W = $clog2(LINE_WORDS);
  localparam int WAIT_W = $clog2(ACCESS_WAIT + 1);

  bus_phase_e          phase_q, phase_d;
  logic                we_q, we_d;
  logic [ADDR_W-1:0]   addr_q;
  logic [WSEL_W-1:0]   word_q, word_d;
  logic [WAIT_W-1:0]   wait_q, wait_d;
  logic                last_word;

  assign last_word = (word_q == WSEL_W'(LINE_WORDS - 1));

  always_comb begin
    phase_d = phase_q;
    we_d    = we_q;
    word_d  = word_q;
    wait_d  = wait_q;
    unique case (phase_q)
      BUS_IDLE: if (start_i) begin
        phase_d = BUS_ADDR;
        we_d    = start_we_i;
        word_d  = '0;
      end
      BUS_ADDR: begin
        phase_d = BUS_WAIT;
        wait_d  = '0;
      end
      BUS_WAIT: begin
        if (wait_q == WAIT_W'(ACCESS_WAIT - 1)) phase_d = BUS_BEAT;
        else                                     wait_d  = wait_q + 1'b1;
      end
      BUS_BEAT: begin
        if (last_word) begin
          phase_d = BUS_IDLE;
        end else begin
          phase_d = BUS_WAIT;
          word_d  = word_q + 1'b1;
          wait_d  = '0;
        end
      end
      default: phase_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= BUS_IDLE;
      we_q    <= 1'b0;
      word_q  <= '0;
      wait_q  <= '0;
    end else begin
      phase_q <= phase_d;
      we_q    <= we_d;
      word_q  <= word_d;
      wait_q  <= wait_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_i && phase_q == BUS_IDLE) addr_q <= start_addr_i;
  end

  assign busy_o = (phase_q != BUS_IDLE);
  assign cmd_o  = (phase_q == BUS_ADDR);
  assign beat_o = (phase_q == BUS_BEAT);
  assign last_o = beat_o && last_word;
  assign we_o   = we_q;
  assign addr_o = addr_q;
  assign word_o = word_q;

endmodule

// File: rtl/wb_cache_lines.sv
module wb_cache_lines #(
  parameter int TAG_W      = 20,
  parameter int INDEX_W    = 8,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [INDEX_W-1:0]                    idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0]         word_i,
  output logic [TAG_W-1:0]                      tag_o,
  output logic                                  valid_o,
  output logic                                  dirty_o,
  output logic [WORD_W-1:0]                     word_data_o,
  output logic [LINE_WORDS-1:0][WORD_W-1:0]     line_o,
  input  logic                                  alloc_i,
  input  logic [TAG_W-1:0]                      alloc_tag_i,
  input  logic                                  fill_i,
  input  logic [$clog2(LINE_WORDS)-1:0]         fill_word_i,
  input  logic [WORD_W-1:0]                     fill_data_i,
  input  logic                                  seal_i,
  input  logic                                  store_i,
  input  logic [WORD_W-1:0]                     store_data_i
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0]                  valid_q, valid_d;
  logic [LINES-1:0]                  dirty_q, dirty_d;
  logic [TAG_W-1:0]                  tag_q  [LINES];
  logic [LINE_WORDS-1:0][WORD_W-1:0] data_q [LINES];

  always_comb begin
    valid_d = valid_q;
    dirty_d = dirty_q;
    if (alloc_i) begin
      valid_d[idx_i] = 1'b0;
      dirty_d[idx_i] = 1'b0;
    end
    if (seal_i)  valid_d[idx_i] = 1'b1;
    if (store_i) dirty_d[idx_i] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_d;
      dirty_q <= dirty_d;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_i) tag_q[idx_i] <= alloc_tag_i;
  end

  always_ff @(posedge clk) begin
    if (fill_i)  data_q[idx_i][fill_word_i] <= fill_data_i;
    if (store_i) data_q[idx_i][word_i]      <= store_data_i;
  end

  assign tag_o       = tag_q[idx_i];
  assign valid_o     = valid_q[idx_i];
  assign dirty_o     = dirty_q[idx_i];
  assign line_o      = data_q[idx_i];
  assign word_data_o = data_q[idx_i][word_i];

endmodule

// File: rtl/wb_cache_victim_buf.sv
module wb_cache_victim_buf #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int WORD_W     = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              load_i,
  input  logic [ADDR_W-1:0]                 load_addr_i,
  input  logic [LINE_WORDS-1:0][WORD_W-1:0] load_line_i,
  input  logic                              drain_i,
  input  logic [$clog2(LINE_WORDS)-1:0]     word_i,
  output logic                              full_o,
  output logic [ADDR_W-1:0]                 addr_o,
  output logic [WORD_W-1:0]                 word_data_o
);
  logic                              full_q, full_d;
  logic [ADDR_W-1:0]                 addr_q;
  logic [LINE_WORDS-1:0][WORD_W-1:0] line_q;

  always_comb begin
    full_d = full_q;
    if (load_i)       full_d = 1'b1;
    else if (drain_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load_i) begin
      addr_q <= load_addr_i;
      line_q <= load_line_i;
    end
  end

  assign full_o      = full_q;
  assign addr_o      = addr_q;
  assign word_data_o = line_q[word_i];

endmodule

// File: rtl/wb_cache.sv
module wb_cache
  import wb_cache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int WORD_W      = 32,
  parameter int INDEX_W     = 8,
  parameter int LINE_WORDS  = 4,
  parameter int ACCESS_WAIT = 15
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cpu_req,
  input  logic                          cpu_we,
  input  logic [ADDR_W-1:0]             cpu_addr,
  input  logic [WORD_W-1:0]             cpu_wdata,
  output logic                          cpu_done,
  output logic [WORD_W-1:0]             cpu_rdata,
  output logic                          mem_cmd,
  output logic                          mem_we,
  output logic [ADDR_W-1:0]             mem_addr,
  output logic                          mem_beat,
  output logic [$clog2(LINE_WORDS)-1:0] mem_word,
  output logic [WORD_W-1:0]             mem_wdata,
  input  logic [WORD_W-1:0]             mem_rdata
);
  localparam int WSEL_W   = $clog2(LINE_WORDS);
  localparam int BYTE_W   = $clog2(WORD_W / 8);
  localparam int OFFSET_W = WSEL_W + BYTE_W;
  localparam int TAG_W    = ADDR_W - INDEX_W - OFFSET_W;

  // reset: asserted at once, released two edges later
  logic [1:0] rst_pipe_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  // address fields
  logic [TAG_W-1:0]   req_tag;
  logic [INDEX_W-1:0] req_idx;
  logic [WSEL_W-1:0]  req_word;
  logic               unused_byte_bits;

  assign req_tag          = cpu_addr[ADDR_W-1 -: TAG_W];
  assign req_idx          = cpu_addr[OFFSET_W +: INDEX_W];
  assign req_word         = cpu_addr[BYTE_W +: WSEL_W];
  assign unused_byte_bits = ^cpu_addr[BYTE_W-1:0];

  // internal connections
  logic [TAG_W-1:0]                  look_tag;
  logic                              look_valid, look_dirty;
  logic [WORD_W-1:0]                 look_word;
  logic [LINE_WORDS-1:0][WORD_W-1:0] look_line;
  logic                              ebuf_full;
  logic [ADDR_W-1:0]                 ebuf_addr;
  logic                              bus_busy, bus_last;
  logic                              bus_start, bus_start_we;
  logic [ADDR_W-1:0]                 bus_start_addr;

  ctl_state_e state_q, state_d;
  logic       hit, serve, miss_go, wb_go, evict_load, fill, seal, drain;

  assign hit        = look_valid && (look_tag == req_tag);
  assign serve      = (state_q == CTL_IDLE) && cpu_req && hit;
  assign miss_go    = (state_q == CTL_IDLE) && cpu_req && !hit && !ebuf_full && !bus_busy;
  assign wb_go      = ebuf_full && !bus_busy;
  assign evict_load = miss_go && look_valid && look_dirty;
  assign fill       = (state_q == CTL_FILL) && mem_beat && !mem_we;
  assign seal       = (state_q == CTL_FILL) && bus_last;
  assign drain      = bus_last && mem_we;

  assign bus_start      = miss_go || wb_go;
  assign bus_start_we   = wb_go;
  assign bus_start_addr = wb_go ? ebuf_addr : {req_tag, req_idx, {OFFSET_W{1'b0}}};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CTL_IDLE: if (miss_go) state_d = CTL_FILL;
      CTL_FILL: if (seal)    state_d = CTL_IDLE;
      default:               state_d = CTL_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= CTL_IDLE;
    else            state_q <= state_d;
  end

  wb_cache_lines #(
    .TAG_W(TAG_W), .INDEX_W(INDEX_W), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
  ) u_lines (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .idx_i        (req_idx),
    .word_i       (req_word),
    .tag_o        (look_tag),
    .valid_o      (look_valid),
    .dirty_o      (look_dirty),
    .word_data_o  (look_word),
    .line_o       (look_line),
    .alloc_i      (miss_go),
    .alloc_tag_i  (req_tag),
    .fill_i       (fill),
    .fill_word_i  (mem_word),
    .fill_data_i  (mem_rdata),
    .seal_i       (seal),
    .store_i      (serve && cpu_we),
    .store_data_i (cpu_wdata)
  );

  wb_cache_victim_buf #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .WORD_W(WORD_W)
  ) u_ebuf (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .load_i      (evict_load),
    .load_addr_i ({look_tag, req_idx, {OFFSET_W{1'b0}}}),
    .load_line_i (look_line),
    .drain_i     (drain),
    .word_i      (mem_word),
    .full_o      (ebuf_full),
    .addr_o      (ebuf_addr),
    .word_data_o (mem_wdata)
  );

  wb_cache_bus_seq #(
    .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS), .ACCESS_WAIT(ACCESS_WAIT)
  ) u_bus (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .start_i      (bus_start),
    .start_we_i   (bus_start_we),
    .start_addr_i (bus_start_addr),
    .busy_o       (bus_busy),
    .last_o       (bus_last),
    .cmd_o        (mem_cmd),
    .we_o         (mem_we),
    .addr_o       (mem_addr),
    .beat_o       (mem_beat),
    .word_o       (mem_word)
  );

  assign cpu_done  = serve;
  assign cpu_rdata = look_word;

endmodule

// File: rtl/wb_cache_checker.sv
module wb_cache_checker #(
  parameter int ADDR_W      = 32,
  parameter int ACCESS_WAIT = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              mem_cmd,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_beat,
  input logic              evict_full
);
  localparam int GAP_W   = $clog2(ACCESS_WAIT + 3);
  localparam int GAP_MAX = (1 << GAP_W) - 1;

  // cycles since the last command or beat, saturating
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       gap_q <= GAP_W'(GAP_MAX);
    else if (mem_cmd || mem_beat)     gap_q <= GAP_W'(1);
    else if (gap_q != GAP_W'(GAP_MAX)) gap_q <= gap_q + 1'b1;
  end

  p_beat_spacing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_beat |-> (gap_q == GAP_W'(ACCESS_WAIT + 1)));

  p_cmd_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd |=> !mem_cmd);

  p_cmd_beat_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_cmd && mem_beat));

  p_bus_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_beat |-> ($stable(mem_addr) && $stable(mem_we)));

  p_done_with_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> cpu_req);

  p_refill_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evict_full) |-> (mem_cmd && !mem_we));

endmodule

bind wb_cache wb_cache_checker #(
  .ADDR_W(ADDR_W), .ACCESS_WAIT(ACCESS_WAIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_req    (cpu_req),
  .cpu_done   (cpu_done),
  .mem_cmd    (mem_cmd),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_beat   (mem_beat),
  .evict_full (ebuf_full)
);

// File: tb/wb_cache_tb.sv
module wb_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MWORDS     = 4096;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata, cpu_rdata;
  logic        cpu_done;
  logic        mem_cmd, mem_we, mem_beat;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_cache u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
    .cpu_rdata(cpu_rdata), .mem_cmd(mem_cmd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_beat(mem_beat), .mem_word(mem_word),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  logic [31:0] dram    [MWORDS];
  logic [31:0] ref_mem [MWORDS];
  bit          m_valid [256];
  bit          m_dirty [256];
  logic [19:0] m_tag   [256];
  int          exp_wr = 0;

  function automatic logic [31:0] init_word(int i);
    return 32'hA500_0000 + i * 32'h0001_0003;
  endfunction

  function automatic logic [31:0] mk(int tag, int idx, int word);
    return {20'(tag), 8'(idx), 2'(word), 2'b00};
  endfunction

  function automatic int midx(logic [31:0] a);
    return int'({a[13:12], a[11:4], a[3:2]});
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // memory model: read data during read beats, writes on write beats
  assign mem_rdata = dram[{mem_addr[13:4], mem_word}];
  always @(posedge clk) if (mem_beat && mem_we) dram[{mem_addr[13:4], mem_word}] <= mem_wdata;

  // bus monitor
  int          cyc = 0;
  int          cmd_cyc, beat_n;
  bit          cur_we, tx_busy = 0;
  logic [31:0] cur_addr, last_wr_addr;
  int          n_rd = 0, n_wr = 0, last_rd_cmd = 0, last_wb_end = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && mem_cmd) begin
      cmd_cyc = cyc; beat_n = 0; cur_we = mem_we; cur_addr = mem_addr; tx_busy = 1;
      chk(mem_addr[3:0] == 4'h0, "R12", "line address low bits", mem_addr, {mem_addr[31:4], 4'h0});
      if (mem_we) begin n_wr++; last_wr_addr = mem_addr; end
      else begin n_rd++; last_rd_cmd = cyc; end
    end
    if (rst_n && mem_beat) begin
      chk(32'(mem_word) == 32'(beat_n), "R8", "beat word order", 32'(mem_word), 32'(beat_n));
      chk(cyc - cmd_cyc == 16 * (beat_n + 1), "R8", "beat timing", 32'(cyc - cmd_cyc), 32'(16 * (beat_n + 1)));
      chk(mem_addr == cur_addr && mem_we == cur_we, "R12", "address held", mem_addr, cur_addr);
      beat_n++;
      if (beat_n == 4) begin
        tx_busy = 0;
        if (cur_we) last_wb_end = cyc;
      end
    end
  end

  // one access; returns data, cycles waited and the predicted hit
  task automatic acc(input bit we, input logic [31:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output int n, output bit exp_hit,
                     output logic [31:0] exp_rd);
    int line;
    line    = int'(a[11:4]);
    exp_hit = m_valid[line] && (m_tag[line] == a[31:12]);
    exp_rd  = ref_mem[midx(a)];
    if (!exp_hit) begin
      if (m_valid[line] && m_dirty[line]) exp_wr++;
      m_valid[line] = 1; m_tag[line] = a[31:12]; m_dirty[line] = 0;
    end
    if (we) begin m_dirty[line] = 1; ref_mem[midx(a)] = wd; end
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    n = 0;
    while (1) begin
      #(CLK_PERIOD/4);
      if (cpu_done) break;
      @(negedge clk);
      n++;
      if (n > 5000) begin
        chk(0, "R9", "request never completed", 32'(n), 32'd66);
        break;
      end
    end
    rd = cpu_rdata;
    @(posedge clk);
    #1 cpu_req = 0;
  endtask

  logic [31:0] rd, erd;
  int          n, rd0;
  bit          eh;

  initial begin
    for (int i = 0; i < MWORDS; i++) begin dram[i] = init_word(i); ref_mem[i] = init_word(i); end
    for (int i = 0; i < 256; i++) begin m_valid[i] = 0; m_dirty[i] = 0; m_tag[i] = '0; end
    rst_n = 0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!cpu_done && !mem_cmd && !mem_beat, "R2", "quiet after reset",
        {29'd0, cpu_done, mem_cmd, mem_beat}, 32'd0);

    // first access misses, full-line refill, 66 cycles
    acc(0, mk(0,5,2), 0, rd, n, eh, erd);
    chk(n == 66, "R2", "first access is a miss", 32'(n), 32'd66);
    chk(n == 66, "R9", "miss latency", 32'(n), 32'd66);
    chk(rd == erd, "R5", "refill data", rd, erd);
    chk(n_rd == 1, "R5", "one read", 32'(n_rd), 32'd1);

    rd0 = n_rd;
    acc(0, mk(0,5,0), 0, rd, n, eh, erd);
    chk(n == 0, "R1", "other word of same line hits", 32'(n), 32'd0);
    chk(rd == erd && n_rd == rd0, "R3", "hit data, no bus read", rd, erd);

    acc(0, mk(0,9,1), 0, rd, n, eh, erd);
    chk(n_wr == 0, "R5", "clean miss writes nothing", 32'(n_wr), 32'd0);

    rd0 = n_rd;
    acc(1, mk(0,5,1), 32'hDEAD_0001, rd, n, eh, erd);
    chk(n == 0 && n_rd == rd0 && n_wr == 0, "R4", "store hit stays in cache", 32'(n), 32'd0);
    acc(0, mk(0,5,1), 0, rd, n, eh, erd);
    chk(rd == 32'hDEAD_0001, "R4", "store hit visible", rd, 32'hDEAD_0001);

    // dirty victim: read first, then write
    acc(0, mk(1,5,0), 0, rd, n, eh, erd);
    chk(n == 66, "R1", "tag bit 12 change misses", 32'(n), 32'd66);
    chk(n_wr == 0, "R6", "no write before refill done", 32'(n_wr), 32'd0);
    chk(rd == erd, "R6", "new line data", rd, erd);
    acc(0, mk(0,9,1), 0, rd, n, eh, erd);
    chk(n == 0 && rd == erd, "R10", "hit during writeback", 32'(n), 32'd0);
    chk(tx_busy && cur_we, "R10", "writeback in progress", {31'd0, tx_busy}, 32'd1);
    repeat (80) @(negedge clk);
    chk(n_wr == 1 && last_wr_addr == mk(0,5,0), "R6", "victim block address", last_wr_addr, mk(0,5,0));
    chk(dram[midx(mk(0,5,1))] == 32'hDEAD_0001, "R6", "victim word", dram[midx(mk(0,5,1))], 32'hDEAD_0001);
    chk(dram[midx(mk(0,5,0))] == init_word(midx(mk(0,5,0))), "R6", "victim clean word",
        dram[midx(mk(0,5,0))], init_word(midx(mk(0,5,0))));

    // store miss allocates and merges
    rd0 = n_rd;
    acc(1, mk(2,7,3), 32'hBEEF_0007, rd, n, eh, erd);
    chk(n == 66 && n_rd == rd0 + 1, "R7", "store miss fetches line", 32'(n), 32'd66);
    acc(0, mk(2,7,0), 0, rd, n, eh, erd);
    chk(n == 0 && rd == init_word(midx(mk(2,7,0))), "R7", "fetched word kept", rd, init_word(midx(mk(2,7,0))));
    acc(0, mk(2,7,3), 0, rd, n, eh, erd);
    chk(rd == 32'hBEEF_0007, "R7", "merged word", rd, 32'hBEEF_0007);
    acc(0, mk(3,7,0), 0, rd, n, eh, erd);
    repeat (80) @(negedge clk);
    chk(last_wr_addr == mk(2,7,0), "R7", "dirty after store miss", last_wr_addr, mk(2,7,0));
    chk(dram[midx(mk(2,7,3))] == 32'hBEEF_0007, "R7", "stored word in memory", dram[midx(mk(2,7,3))], 32'hBEEF_0007);

    // miss right behind a dirty eviction stalls for the drain
    acc(1, mk(0,20,0), 32'h1234_5678, rd, n, eh, erd);
    acc(0, mk(1,20,0), 0, rd, n, eh, erd);
    chk(n == 66, "R6", "dirty-victim miss latency", 32'(n), 32'd66);
    acc(0, mk(1,21,0), 0, rd, n, eh, erd);
    chk(n > 66, "R11", "second miss stalled", 32'(n), 32'd67);
    chk(last_rd_cmd == last_wb_end + 2, "R11", "read after drain", 32'(last_rd_cmd), 32'(last_wb_end + 2));
    chk(rd == erd, "R11", "stalled miss data", rd, erd);

    // random traffic on a few lines and tags
    void'($urandom(32'd20240611));
    for (int k = 0; k < 300; k++) begin
      automatic bit          w = ($urandom_range(0, 9) < 4);
      automatic logic [31:0] a = mk($urandom_range(0, 3), 40 + $urandom_range(0, 5), $urandom_range(0, 3));
      automatic logic [31:0] d = $urandom;
      rd0 = n_rd;
      acc(w, a, d, rd, n, eh, erd);
      if (!w) chk(rd == erd, "R3", "random load value", rd, erd);
      if (eh) chk(n == 0 && n_rd == rd0, "R3", "random hit no stall", 32'(n), 32'd0);
      else    chk(n >= 66 && n_rd == rd0 + 1, "R5", "random miss one read", 32'(n), 32'd66);
    end
    repeat (200) @(negedge clk);
    chk(n_wr == exp_wr, "R6", "writeback count", 32'(n_wr), 32'(exp_wr));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule